// File: doc/BRIEF.md
# Event-Triggered Single-Channel Byte Mover

This block moves bytes from one memory window to another with no processor in the loop. Software programs a source base, a destination base, independent source and destination lengths, and a burst length in bytes. A start event is either a software force bit or a rising edge on a selected device interrupt line. Each start event moves one burst, one byte at a time. Each byte is a read on a request/grant memory bus followed by a write.

Two read-only pointers show how far each side has advanced. Sticky flags report when each side reaches half and all of its length. A block ends when the longer side has been covered, and the shorter side wraps around meanwhile. A block can also end early when a byte that matches a programmed value has been copied. When a block ends, the channel switches itself off unless it is set to re-arm itself.

A transfer can be aborted in four ways: by software, by a second selected interrupt line, by a bus error, or by an address outside a legal window. An abort always lets the byte in flight finish first. An abort issued while the channel is paused keeps the pointers, so the stall can be inspected.

Top module: `dmac_chan`

## Requirements
- R1: No bus request is made unless the global enable (cfg_sel 0, bit 0) and the channel enable (cfg_sel 1, bit 0) are both set. Starts that arrive while either enable is clear are dropped.
- R2: A start event is a write to cfg_sel 7 with bit 0 set, or a rising edge of irq_lines[n] while start-on-interrupt is enabled (cfg_sel 1, bit 2), where n is cfg_sel 1 bits [15:8]. Edges on other lines do nothing, and so do starts while a burst is active.
- R3: Each start event moves cell-size bytes (cfg_sel 6). Each byte is a bus read of the source followed by a bus write of the same data to the destination.
- R4: The source and destination pointers each advance by one after every byte has been written. The read address is source base (cfg_sel 2) plus the source pointer, and the write address is destination base (cfg_sel 3) plus the destination pointer.
- R5: Sticky flags are set when a pointer reaches half of its size and when it reaches its full size (source size cfg_sel 4, destination size cfg_sel 5). Writing cfg_sel 7 with bit 2 set clears all flags.
- R6: A block completes after max(source size, destination size) bytes. Both pointers then return to zero, and the channel enable clears unless auto re-arm (cfg_sel 1, bit 1) is set.
- R7: A pointer that reaches its own size before the block completes wraps to zero, so the shorter side repeats.
- R8: With auto re-arm set, the channel enable stays set after a block completes, and a new start event is accepted.
- R9: Clearing the global enable stops the channel and resets both pointers.
- R10: With pattern matching enabled (cfg_sel 1, bit 4) and auto re-arm clear, copying a byte equal to cfg_sel 1 bits [31:24] ends the block. The matching byte is still written.
- R11: An abort comes from a cfg_sel 7 write with bit 1 set, from a rising edge on irq_lines[m] while abort-on-interrupt (cfg_sel 1, bit 3) is set (m is cfg_sel 1 bits [23:16]), from a bus error response, or from an address outside LEGAL_LO..LEGAL_HI. An abort sets flag_abort, lets a byte in flight finish, ends the burst and resets the pointers.
- R12: An abort while the channel is paused mid-burst (channel enable cleared, or suspend, cfg_sel 0 bit 1, set) sets flag_abort and cancels the burst. The source, destination and cell pointers keep their values.
- R13: Writing the source base resets only the source pointer. Writing the destination base resets only the destination pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| irq_lines | input | NIRQ | Device interrupt lines usable as events |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | AW | Bus byte address |
| mem_wdata | output | 8 | Bus write data |
| mem_gnt | input | 1 | Bus grant; completes the request in this cycle |
| mem_rdata | input | 8 | Bus read data, valid with grant |
| mem_err | input | 1 | Bus error response, valid with grant |
| src_ptr | output | AW | Source pointer |
| dst_ptr | output | AW | Destination pointer |
| cell_ptr | output | AW | Bytes moved in the current burst |
| chan_on | output | 1 | Channel enable state |
| busy | output | 1 | A burst is active or paused |
| flag_src_half | output | 1 | Source reached half size |
| flag_src_full | output | 1 | Source reached full size |
| flag_dst_half | output | 1 | Destination reached half size |
| flag_dst_full | output | 1 | Destination reached full size |
| flag_abort | output | 1 | Channel aborted |

## Verification
A corrupt pointer shows up at once on mem_addr in the next read or write. It also shows up as a wrong byte landing at the destination, and src_ptr or dst_ptr report it directly. A wrong block count or a missed wrap shows up when the burst or block ends: chan_on drops at the wrong byte, or the full flags rise at the wrong time. Faults in the abort or pause state are visible within a few cycles of the abort stimulus. They appear as flag_abort, as pointers that were kept or zeroed when they should not have been, or as bus activity that continues after a pause.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_t;

   localparam int CFG_W = 32;

   localparam logic [2:0] SEL_CTRL     = 3'd0;
   localparam logic [2:0] SEL_CHAN     = 3'd1;
   localparam logic [2:0] SEL_SRC_BASE = 3'd2;
   localparam logic [2:0] SEL_DST_BASE = 3'd3;
   localparam logic [2:0] SEL_SRC_SIZE = 3'd4;
   localparam logic [2:0] SEL_DST_SIZE = 3'd5;
   localparam logic [2:0] SEL_CELL     = 3'd6;
   localparam logic [2:0] SEL_CMD      = 3'd7;
endpackage

// File: rtl/dmac_evt_sel.sv
module dmac_evt_sel #(
   parameter int NIRQ = 8,
   localparam int IW = $clog2(NIRQ)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] irq,
   input  logic [IW-1:0]   num,
   input  logic            en,
   output logic            hit
);
   logic [NIRQ-1:0] irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq;
   end

   assign hit = en && irq[num] && !irq_q[num];
endmodule

// File: rtl/dmac_side_ptr.sv
module dmac_side_ptr #(
   parameter int AW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [AW-1:0] size,
   output logic [AW-1:0] ptr,
   output logic          half_hit,
   output logic          full_hit
);
   localparam logic [AW:0] ONE_X = 1;
   logic [AW:0] nxt;

   assign nxt      = {1'b0, ptr} + ONE_X;
   assign full_hit = step && (nxt == {1'b0, size});
   assign half_hit = step && (nxt == {2'b00, size[AW-1:1]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr <= '0;
      else if (clr)      ptr <= '0;
      else if (full_hit) ptr <= '0;
      else if (step)     ptr <= nxt[AW-1:0];
   end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
   import dmac_pkg::*;
#(
   parameter int          AW          = 8,
   parameter int          NIRQ        = 8,
   parameter bit          RANGE_CHECK = 1'b1,
   parameter int unsigned LEGAL_LO    = 0,
   parameter int unsigned LEGAL_HI    = 239
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [2:0]       cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic [NIRQ-1:0]  irq_lines,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [7:0]       mem_wdata,
   input  logic             mem_gnt,
   input  logic [7:0]       mem_rdata,
   input  logic             mem_err,
   output logic [AW-1:0]    src_ptr,
   output logic [AW-1:0]    dst_ptr,
   output logic [AW-1:0]    cell_ptr,
   output logic             chan_on,
   output logic             busy,
   output logic             flag_src_half,
   output logic             flag_src_full,
   output logic             flag_dst_half,
   output logic             flag_dst_full,
   output logic             flag_abort
);
   localparam int          IW    = $clog2(NIRQ);
   localparam logic [AW-1:0] LO_A = AW'(LEGAL_LO);
   localparam logic [AW-1:0] HI_A = AW'(LEGAL_HI);
   localparam logic [AW-1:0] ONE_A = 1;

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("dmac_chan: AW must lie in 2..16");
   end
   if (NIRQ < 2 || NIRQ > 256 || (NIRQ & (NIRQ - 1)) != 0) begin : g_bad_nirq
      $error("dmac_chan: NIRQ must be a power of two in 2..256");
   end
   if (LEGAL_LO > LEGAL_HI || LEGAL_HI >= (1 << AW)) begin : g_bad_range
      $error("dmac_chan: legal window does not fit the address space");
   end

   // configuration state
   logic          glob_on, suspend, ch_en, auto_en, sirq_en, airq_en, pat_en;
   logic [IW-1:0] sirq_num, airq_num;
   logic [7:0]    pattern;
   logic [AW-1:0] src_base, dst_base, src_size, dst_size, cell_size;
   // transfer state
   xfer_st_t      state;
   logic          active, abort_pend;
   logic [7:0]    data_q;
   logic [AW-1:0] blk_cnt;

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^cfg_wdata;

   logic wr_ctrl, wr_chan, wr_cmd, wr_sbase, wr_dbase;
   logic force_w, abort_w, clr_w, off_now;
   assign wr_ctrl  = cfg_wr && (cfg_sel == SEL_CTRL);
   assign wr_chan  = cfg_wr && (cfg_sel == SEL_CHAN);
   assign wr_cmd   = cfg_wr && (cfg_sel == SEL_CMD);
   assign wr_sbase = cfg_wr && (cfg_sel == SEL_SRC_BASE);
   assign wr_dbase = cfg_wr && (cfg_sel == SEL_DST_BASE);
   assign force_w  = wr_cmd && cfg_wdata[0];
   assign abort_w  = wr_cmd && cfg_wdata[1];
   assign clr_w    = wr_cmd && cfg_wdata[2];
   assign off_now  = wr_ctrl && !cfg_wdata[0];

   logic sirq_hit, airq_hit;
   dmac_evt_sel #(.NIRQ(NIRQ)) u_start_evt (
      .clk(clk), .rst_n(rst_n), .irq(irq_lines), .num(sirq_num), .en(sirq_en), .hit(sirq_hit));
   dmac_evt_sel #(.NIRQ(NIRQ)) u_abort_evt (
      .clk(clk), .rst_n(rst_n), .irq(irq_lines), .num(airq_num), .en(airq_en), .hit(airq_hit));

   logic start_ev, abort_ev, run;
   assign start_ev = force_w || sirq_hit;
   assign abort_ev = abort_w || airq_hit;
   assign run      = glob_on && ch_en && !suspend;

   logic [AW-1:0] src_addr, dst_addr;
   assign src_addr = src_base + src_ptr;
   assign dst_addr = dst_base + dst_ptr;

   logic addr_ok;
   if (RANGE_CHECK) begin : g_range
      assign addr_ok = (src_addr >= LO_A) && (src_addr <= HI_A) &&
                       (dst_addr >= LO_A) && (dst_addr <= HI_A);
   end else begin : g_no_range
      assign addr_ok = 1'b1;
   end

   assign mem_req   = (state != ST_IDLE);
   assign mem_we    = (state == ST_WR);
   assign mem_addr  = (state == ST_WR) ? dst_addr : src_addr;
   assign mem_wdata = data_q;

   logic byte_done, bus_err, go, range_err, pend_fire, keep_ptrs, abort_fire;
   logic blk_last, pat_hit, blk_end, cell_end, ptr_clr;
   logic [AW-1:0] max_size;
   assign byte_done  = (state == ST_WR) && mem_gnt && !mem_err;
   assign bus_err    = (state != ST_IDLE) && mem_gnt && mem_err;
   assign go         = glob_on && (state == ST_IDLE) && !abort_pend && active && run;
   assign range_err  = go && !addr_ok;
   assign pend_fire  = glob_on && (state == ST_IDLE) && abort_pend;
   assign keep_ptrs  = pend_fire && active && !run;
   assign abort_fire = pend_fire || bus_err || range_err;
   assign max_size   = (src_size > dst_size) ? src_size : dst_size;
   assign blk_last   = byte_done && ((blk_cnt + ONE_A) == max_size);
   assign pat_hit    = byte_done && pat_en && !auto_en && (data_q == pattern);
   assign blk_end    = blk_last || pat_hit;
   assign cell_end   = byte_done && ((cell_ptr + ONE_A) == cell_size);
   assign ptr_clr    = !glob_on || off_now || blk_end || (abort_fire && !keep_ptrs);

   logic s_half, s_full, d_half, d_full;
   dmac_side_ptr #(.AW(AW)) u_src_side (
      .clk(clk), .rst_n(rst_n), .clr(ptr_clr || wr_sbase), .step(byte_done),
      .size(src_size), .ptr(src_ptr), .half_hit(s_half), .full_hit(s_full));
   dmac_side_ptr #(.AW(AW)) u_dst_side (
      .clk(clk), .rst_n(rst_n), .clr(ptr_clr || wr_dbase), .step(byte_done),
      .size(dst_size), .ptr(dst_ptr), .half_hit(d_half), .full_hit(d_full));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_on <= 1'b0; suspend <= 1'b0; ch_en <= 1'b0; auto_en <= 1'b0;
         sirq_en <= 1'b0; airq_en <= 1'b0; pat_en <= 1'b0;
         sirq_num <= '0; airq_num <= '0; pattern <= '0;
         src_base <= '0; dst_base <= '0; src_size <= '0; dst_size <= '0; cell_size <= '0;
      end else begin
         if (wr_ctrl) begin
            glob_on <= cfg_wdata[0];
            suspend <= cfg_wdata[1];
         end
         if (wr_chan) begin
            ch_en    <= cfg_wdata[0];
            auto_en  <= cfg_wdata[1];
            sirq_en  <= cfg_wdata[2];
            airq_en  <= cfg_wdata[3];
            pat_en   <= cfg_wdata[4];
            sirq_num <= cfg_wdata[8 +: IW];
            airq_num <= cfg_wdata[16 +: IW];
            pattern  <= cfg_wdata[31:24];
         end else if (blk_end && !auto_en) begin
            ch_en <= 1'b0;
         end
         if (wr_sbase) src_base <= cfg_wdata[AW-1:0];
         if (wr_dbase) dst_base <= cfg_wdata[AW-1:0];
         if (cfg_wr && cfg_sel == SEL_SRC_SIZE) src_size  <= cfg_wdata[AW-1:0];
         if (cfg_wr && cfg_sel == SEL_DST_SIZE) dst_size  <= cfg_wdata[AW-1:0];
         if (cfg_wr && cfg_sel == SEL_CELL)     cell_size <= cfg_wdata[AW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; active <= 1'b0; abort_pend <= 1'b0;
         data_q <= '0; blk_cnt <= '0; cell_ptr <= '0;
      end else if (!glob_on || off_now) begin
         state <= ST_IDLE; active <= 1'b0; abort_pend <= 1'b0; blk_cnt <= '0;
      end else begin
         if (abort_ev) abort_pend <= 1'b1;
         if (ptr_clr)        blk_cnt <= '0;
         else if (byte_done) blk_cnt <= blk_cnt + ONE_A;
         if (byte_done) cell_ptr <= cell_ptr + ONE_A;
         unique case (state)
            ST_IDLE: begin
               if (abort_pend) begin
                  active <= 1'b0; abort_pend <= 1'b0;
               end else if (range_err) begin
                  active <= 1'b0;
               end else if (go) begin
                  state <= ST_RD;
               end else if (start_ev && ch_en && !active) begin
                  active <= 1'b1; cell_ptr <= '0;
               end
            end
            ST_RD: if (mem_gnt) begin
               if (mem_err) begin
                  state <= ST_IDLE; active <= 1'b0; abort_pend <= 1'b0;
               end else begin
                  data_q <= mem_rdata; state <= ST_WR;
               end
            end
            ST_WR: if (mem_gnt) begin
               state <= ST_IDLE;
               if (mem_err) begin
                  active <= 1'b0; abort_pend <= 1'b0;
               end else if (cell_end || blk_end) begin
                  active <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_src_half <= 1'b0; flag_src_full <= 1'b0;
         flag_dst_half <= 1'b0; flag_dst_full <= 1'b0; flag_abort <= 1'b0;
      end else begin
         if (clr_w) begin
            flag_src_half <= 1'b0; flag_src_full <= 1'b0;
            flag_dst_half <= 1'b0; flag_dst_full <= 1'b0; flag_abort <= 1'b0;
         end
         if (s_half) flag_src_half <= 1'b1;
         if (s_full) flag_src_full <= 1'b1;
         if (d_half) flag_dst_half <= 1'b1;
         if (d_full) flag_dst_full <= 1'b1;
         if (abort_fire) flag_abort <= 1'b1;
      end
   end

   assign chan_on = ch_en;
   assign busy    = active;
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
   parameter int AW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic          glob_on,
   input logic          chan_on,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_gnt,
   input logic          mem_err,
   input logic          flag_abort,
   input logic [AW-1:0] src_ptr,
   input logic [AW-1:0] dst_ptr
);
   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_on |-> !mem_req);

   // R1
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(glob_on && chan_on));

   // R9
   off_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_on |-> (src_ptr == '0 && dst_ptr == '0));

   // R3
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_gnt && !mem_err) |=> ((mem_req && mem_we) || !glob_on));

   // R11
   abort_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_abort) |-> $past(!mem_req || mem_gnt));
endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW)) u_chan_chk (
   .clk(clk), .rst_n(rst_n), .glob_on(glob_on), .chan_on(ch_en), .busy(active),
   .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_err(mem_err),
   .flag_abort(flag_abort), .src_ptr(src_ptr), .dst_ptr(dst_ptr));

// File: tb/dmac_chan_test.sv
`timescale 1ns/1ps
module dmac_chan_test;
   localparam int AW = 8;
   localparam int NIRQ = 8;
   localparam logic [7:0] SRC = 8'h10;
   localparam logic [7:0] DST = 8'h80;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [NIRQ-1:0] irq_lines = '0;
   logic mem_req, mem_we, mem_gnt, mem_err;
   logic [AW-1:0] mem_addr, src_ptr, dst_ptr, cell_ptr;
   logic [7:0] mem_wdata, mem_rdata;
   logic chan_on, busy, flag_src_half, flag_src_full, flag_dst_half, flag_dst_full, flag_abort;
   logic stall = 1'b0, err_inj = 1'b0;
   logic [7:0] mem [0:255];
   int n_cmp = 0, n_bad = 0, req_cnt = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dmac_chan uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .irq_lines(irq_lines), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cell_ptr(cell_ptr), .chan_on(chan_on), .busy(busy),
      .flag_src_half(flag_src_half), .flag_src_full(flag_src_full),
      .flag_dst_half(flag_dst_half), .flag_dst_full(flag_dst_full), .flag_abort(flag_abort));

   assign mem_gnt   = mem_req && !stall;
   assign mem_err   = err_inj;
   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (mem_req) req_cnt = req_cnt + 1;
      if (mem_req && mem_we && mem_gnt && !mem_err) mem[mem_addr] = mem_wdata;
   end

   function automatic logic [7:0] sv(input int i);
      return 8'(i * 3 + 7);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic chan(input bit en, input bit au, input bit se, input bit ae, input bit pe,
                       input logic [7:0] sn, input logic [7:0] an, input logic [7:0] pat);
      cfg(3'd1, {pat, an, sn, 3'b000, pe, ae, se, au, en});
   endtask

   task automatic setup(input logic [7:0] s, input logic [7:0] d, input logic [7:0] ss,
                        input logic [7:0] ds, input logic [7:0] cs);
      cfg(3'd2, {24'd0, s}); cfg(3'd3, {24'd0, d});
      cfg(3'd4, {24'd0, ss}); cfg(3'd5, {24'd0, ds}); cfg(3'd6, {24'd0, cs});
      cfg(3'd7, 32'd4);
      for (int i = 0; i < 32; i++) mem[DST + i] = 8'h00;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (!busy && !mem_req) break;
      end
   endtask

   task automatic pulse(input int line);
      @(negedge clk); irq_lines[line] = 1'b1;
      @(negedge clk); irq_lines[line] = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "reset req", mem_req, 0);
      chk("R4", "reset src_ptr", src_ptr, 0);
      chk("R4", "reset dst_ptr", dst_ptr, 0);
      chk("R11", "reset abort flag", flag_abort, 0);
      chk("R6", "reset chan_on", chan_on, 0);
   endtask

   task automatic t_gate();
      setup(SRC, DST, 8, 8, 4);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      req_cnt = 0;
      cfg(3'd7, 32'd1);
      repeat (20) @(negedge clk);
      chk("R1", "requests with global off", req_cnt, 0);
      chk("R1", "dst untouched", mem[DST], 0);
   endtask

   task automatic t_cell_and_block();
      cfg(3'd0, 32'd1);
      setup(SRC, DST, 8, 8, 4);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      cfg(3'd7, 32'd1); wait_idle();
      chk("R3", "cell_ptr after burst", cell_ptr, 4);
      chk("R4", "src_ptr after burst", src_ptr, 4);
      chk("R4", "dst_ptr after burst", dst_ptr, 4);
      for (int i = 0; i < 4; i++) chk("R3", "copied byte", mem[DST + i], sv(SRC + i));
      chk("R3", "byte past burst", mem[DST + 4], 0);
      chk("R5", "src half flag", flag_src_half, 1);
      chk("R5", "dst half flag", flag_dst_half, 1);
      chk("R5", "src full flag early", flag_src_full, 0);
      cfg(3'd7, 32'd1); wait_idle();
      chk("R6", "src_ptr after block", src_ptr, 0);
      chk("R6", "dst_ptr after block", dst_ptr, 0);
      chk("R5", "src full flag", flag_src_full, 1);
      chk("R5", "dst full flag", flag_dst_full, 1);
      chk("R6", "chan_on after block", chan_on, 0);
      chk("R6", "last byte", mem[DST + 7], sv(SRC + 7));
      cfg(3'd7, 32'd4);
      chk("R5", "flags cleared", {flag_src_half, flag_src_full, flag_dst_half, flag_dst_full}, 0);
      req_cnt = 0;
      cfg(3'd7, 32'd1); repeat (10) @(negedge clk);
      chk("R6", "start ignored while disabled", req_cnt, 0);
   endtask

   task automatic t_irq_start();
      setup(SRC, DST, 8, 8, 2);
      chan(1, 0, 1, 0, 0, 3, 0, 0);
      pulse(2); repeat (10) @(negedge clk);
      chk("R2", "other line ignored", src_ptr, 0);
      pulse(3); wait_idle();
      chk("R2", "selected line starts burst", src_ptr, 2);
      chk("R2", "byte via irq", mem[DST + 1], sv(SRC + 1));
      cfg(3'd0, 32'd0);
      chk("R9", "src_ptr after global off", src_ptr, 0);
      chk("R9", "dst_ptr after global off", dst_ptr, 0);
      cfg(3'd0, 32'd1);
   endtask

   task automatic t_sizes();
      setup(SRC, DST, 4, 8, 8);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      cfg(3'd7, 32'd1); wait_idle();
      for (int i = 0; i < 8; i++) chk("R7", "wrapped source byte", mem[DST + i], sv(SRC + (i % 4)));
      chk("R7", "src full flag", flag_src_full, 1);
      chk("R6", "dst full flag", flag_dst_full, 1);
      chk("R6", "ptr zero", {src_ptr, dst_ptr}, 0);
   endtask

   task automatic t_auto();
      setup(SRC, DST, 4, 4, 4);
      chan(1, 1, 0, 0, 0, 0, 0, 0);
      cfg(3'd7, 32'd1); wait_idle();
      chk("R8", "chan_on kept", chan_on, 1);
      chk("R8", "ptr zero", {src_ptr, dst_ptr}, 0);
      mem[DST] = 8'h00;
      cfg(3'd7, 32'd1); wait_idle();
      chk("R8", "second block copies", mem[DST], sv(SRC));
   endtask

   task automatic t_pattern();
      setup(SRC, DST, 8, 8, 8);
      chan(1, 0, 0, 0, 1, 0, 0, sv(SRC + 2));
      cfg(3'd7, 32'd1); wait_idle();
      chk("R10", "matching byte written", mem[DST + 2], sv(SRC + 2));
      chk("R10", "byte after match", mem[DST + 3], 0);
      chk("R10", "ptrs reset", {src_ptr, dst_ptr}, 0);
      chk("R10", "channel off", chan_on, 0);
   endtask

   task automatic t_abort_write();
      setup(SRC, DST, 8, 8, 8);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      stall = 1'b1;
      cfg(3'd7, 32'd1); repeat (3) @(negedge clk);
      cfg(3'd7, 32'd2); repeat (3) @(negedge clk);
      stall = 1'b0; wait_idle();
      chk("R11", "abort flag", flag_abort, 1);
      chk("R11", "in-flight byte done", mem[DST], sv(SRC));
      chk("R11", "no further byte", mem[DST + 1], 0);
      chk("R11", "ptrs reset", {src_ptr, dst_ptr}, 0);
   endtask

   task automatic t_abort_paused();
      setup(SRC, DST, 8, 8, 8);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      stall = 1'b1;
      cfg(3'd7, 32'd1); repeat (3) @(negedge clk);
      cfg(3'd0, 32'd3);
      stall = 1'b0; repeat (10) @(negedge clk);
      chk("R12", "paused after one byte", src_ptr, 1);
      chk("R12", "still busy while paused", busy, 1);
      cfg(3'd7, 32'd2); repeat (3) @(negedge clk);
      chk("R12", "abort flag", flag_abort, 1);
      chk("R12", "src kept", src_ptr, 1);
      chk("R12", "dst kept", dst_ptr, 1);
      chk("R12", "cell kept", cell_ptr, 1);
      cfg(3'd2, {24'd0, SRC});
      chk("R13", "src reset by base write", src_ptr, 0);
      chk("R13", "dst unaffected", dst_ptr, 1);
      req_cnt = 0;
      cfg(3'd0, 32'd1); repeat (10) @(negedge clk);
      chk("R12", "burst cancelled", req_cnt, 0);
      cfg(3'd3, {24'd0, DST});
      chk("R13", "dst reset by base write", dst_ptr, 0);
   endtask

   task automatic t_errors();
      setup(SRC, DST, 8, 8, 8);
      chan(1, 0, 0, 0, 0, 0, 0, 0);
      err_inj = 1'b1;
      cfg(3'd7, 32'd1); wait_idle();
      err_inj = 1'b0;
      chk("R11", "bus error abort", flag_abort, 1);
      chk("R11", "bus error no write", mem[DST], 0);
      chk("R11", "bus error ptrs", {src_ptr, dst_ptr}, 0);
      setup(8'hF4, DST, 8, 8, 8);
      req_cnt = 0;
      cfg(3'd7, 32'd1); wait_idle();
      chk("R11", "range abort", flag_abort, 1);
      chk("R11", "range no request", req_cnt, 0);
      setup(SRC, DST, 8, 8, 8);
      chan(1, 0, 0, 1, 0, 0, 5, 0);
      stall = 1'b1;
      cfg(3'd7, 32'd1); repeat (3) @(negedge clk);
      pulse(5);
      stall = 1'b0; wait_idle();
      chk("R11", "irq abort flag", flag_abort, 1);
      chk("R11", "irq abort byte done", mem[DST], sv(SRC));
      chk("R11", "irq abort stopped", mem[DST + 1], 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = sv(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gate();
      t_cell_and_block();
      t_irq_start();
      t_sizes();
      t_auto();
      t_pattern();
      t_abort_write();
      t_abort_paused();
      t_errors();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule